// File: doc/BRIEF.md
# Keyed Register Write Protection Guard

This block sits on the write path between a simple register bus and the configuration registers of a peripheral. For every bus write it decodes the target register and produces a one-hot write enable for that register. A protection switch lets software lock the configuration registers. While it is on, writes to the guarded registers are dropped and reported, and writes to the command and interrupt-control registers still reach their targets.

The protection switch has its own protection. It lives in a protection mode register, and it changes only when the upper 24 bits of the same write word carry a fixed unlock key. A write with any other key leaves the switch as it is and is reported as a violation. Every dropped write, and every write with a bad key, sets a violation flag and stores the offset of the register that was targeted. A status read strobe clears both after the read.

Top module: `wprot_guard`

## Requirements
- R1: After synchronous reset, prot_en, viol_flag and viol_src are 0, and no reg_we bit is set while no write is presented.
- R2: While protection is off, a write to a mapped target sets exactly one reg_we bit in the same cycle. The bit index encodes the target: 0 at offset 0x00 (command), 1 at 0x04 (interrupt enable), 2 at 0x08 (interrupt disable), 3 at 0x10 (mode), 4 at 0x14 (frame rate), 5 at 0x18 (display), 6 at 0x1C (segment map low), 7 at 0x20 (segment map high). A write to any other offset sets no bit and records no violation.
- R3: A write to the protection mode register at offset 0x40 whose data bits 31:8 equal 0x4C4344 loads data bit 0 into prot_en. The new value is visible from the next cycle.
- R4: A write to offset 0x40 with any other value in bits 31:8 leaves prot_en unchanged. From the next cycle it shows viol_flag=1 and viol_src=0x0040, whether protection is on or off.
- R5: prot_rdata always reads as prot_en in bit 0 and zero in bits 31:1, so the key field reads back as zero.
- R6: While prot_en=1, a write to offset 0x10, 0x14, 0x18, 0x1C or 0x20 sets no reg_we bit. From the next cycle it shows viol_flag=1 and viol_src equal to that offset. A later violation overwrites the stored offset.
- R7: While prot_en=1, writes to offsets 0x00, 0x04 and 0x08 still set their reg_we bit and record no violation.
- R8: stat_rdata always carries viol_flag in bit 0 and viol_src in bits 23:8, with every other bit zero.
- R9: A cycle with stat_rd=1 clears viol_flag and viol_src from the next cycle, and stat_rdata in that cycle still shows the values from before the clear. If a violation occurs in the same cycle as the read, the new violation is kept.
- R10: A correctly keyed write to offset 0x40 is never blocked, so protection can be turned off while it is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Byte offset of the write |
| bus_wdata | input | 32 | Write data |
| stat_rd | input | 1 | Status register read strobe (clear on read) |
| reg_we | output | 8 | One-hot write enable per target register |
| prot_en | output | 1 | Current protection switch state |
| prot_rdata | output | 32 | Read-back value of the protection mode register |
| viol_flag | output | 1 | Violation flag |
| viol_src | output | 16 | Offset of the most recent violating write |
| stat_rdata | output | 32 | Read-back value of the status register |

## Verification
Some properties are checked on every cycle. reg_we is never more than one-hot. A guarded write under protection never produces an enable. The command register always gets its enable. A bad-key write never moves the switch, and a keyed write always loads the requested bit. A violation always lands in the recorder with the offset of the write. A status read with no new violation always clears the recorder, which otherwise holds its value. Other behaviour is shown only by the bench's scenarios: the exact bit-index mapping of every offset, the read-back layout of both registers, a read in the same cycle as a violation, the last-violation-wins overwrite, and turning protection off again with the key.

// File: rtl/wprot_guard_pkg.sv
package wprot_guard_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int KEY_W   = 24;
    localparam int KEY_LSB = 8;
    localparam int EN_BIT  = 0;
    localparam int SRC_W   = 16;
    localparam int SRC_LSB = 8;
    localparam int NUM_TGT = 8;
    localparam int IDX_W   = $clog2(NUM_TGT);

    localparam logic [KEY_W-1:0]  UNLOCK_KEY = 24'h4C4344;
    localparam logic [ADDR_W-1:0] PROT_OFS   = 8'h40;
    localparam logic [ADDR_W-1:0] STAT_OFS   = 8'h44;

    typedef enum logic [IDX_W-1:0] {
        TGT_CMD   = 3'd0,
        TGT_IEN   = 3'd1,
        TGT_IDIS  = 3'd2,
        TGT_MODE  = 3'd3,
        TGT_FRAME = 3'd4,
        TGT_DISP  = 3'd5,
        TGT_SEG0  = 3'd6,
        TGT_SEG1  = 3'd7
    } tgt_e;

    typedef struct packed {
        logic             flag;
        logic [SRC_W-1:0] src;
    } viol_t;

    function automatic logic [ADDR_W-1:0] tgt_offset(input int idx);
        case (idx)
            0:       tgt_offset = 8'h00;
            1:       tgt_offset = 8'h04;
            2:       tgt_offset = 8'h08;
            3:       tgt_offset = 8'h10;
            4:       tgt_offset = 8'h14;
            5:       tgt_offset = 8'h18;
            6:       tgt_offset = 8'h1C;
            default: tgt_offset = 8'h20;
        endcase
    endfunction

    function automatic logic tgt_guarded(input int idx);
        tgt_guarded = (idx >= int'(TGT_MODE));
    endfunction

endpackage

// File: rtl/wprot_guard_decode.sv
module wprot_guard_decode
    import wprot_guard_pkg::*;
#(
    parameter int N_TGT = NUM_TGT,
    parameter int AW    = ADDR_W
) (
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    output logic [N_TGT-1:0] hit,
    output logic             guarded_hit,
    output logic             prot_hit
);

    logic [N_TGT-1:0] guard_mask;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        assign hit[i]        = wr && (addr == tgt_offset(i));
        assign guard_mask[i] = tgt_guarded(i);
    end

    assign guarded_hit = |(hit & guard_mask);
    assign prot_hit    = wr && (addr == PROT_OFS);

    always_comb begin
        assert_hit_onehot_R2: assert ($onehot0({hit, prot_hit}));
    end

endmodule

// File: rtl/wprot_guard_keyreg.sv
module wprot_guard_keyreg
    import wprot_guard_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int KW = KEY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prot_hit,
    input  logic [KW-1:0] key_in,
    input  logic          en_in,
    output logic          prot_en,
    output logic          key_bad,
    output logic [DW-1:0] rdata
);

    logic key_ok;

    assign key_ok  = prot_hit && (key_in == UNLOCK_KEY);
    assign key_bad = prot_hit && (key_in != UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_en <= 1'b0;
        end else if (key_ok) begin
            prot_en <= en_in;
        end
    end

    always_comb begin
        rdata         = '0;
        rdata[EN_BIT] = prot_en;
    end

    assert_badkey_hold_R4: assert property (@(posedge clk) disable iff (rst)
        key_bad |=> $stable(prot_en));

    assert_key_load_R3: assert property (@(posedge clk) disable iff (rst)
        key_ok |=> (prot_en == $past(en_in)));

endmodule

// File: rtl/wprot_guard_viol.sv
module wprot_guard_viol
    import wprot_guard_pkg::*;
#(
    parameter int SW = SRC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          event_in,
    input  logic [SW-1:0] event_src,
    input  logic          clr,
    output viol_t         state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (event_in) begin
            state.flag <= 1'b1;
            state.src  <= event_src;
        end else if (clr) begin
            state <= '0;
        end
    end

    assert_record_R6: assert property (@(posedge clk) disable iff (rst)
        event_in |=> (state.flag && state.src == $past(event_src)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !event_in) |=> (!state.flag && state.src == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !event_in) |=> $stable(state));

endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
    import wprot_guard_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int SW    = SRC_W,
    parameter int N_TGT = NUM_TGT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             stat_rd,
    output logic [N_TGT-1:0] reg_we,
    output logic             prot_en,
    output logic [DW-1:0]    prot_rdata,
    output logic             viol_flag,
    output logic [SW-1:0]    viol_src,
    output logic [DW-1:0]    stat_rdata
);

    logic [N_TGT-1:0] hit;
    logic             guarded_hit;
    logic             prot_hit;
    logic             key_bad;
    logic             blocked;
    logic             viol_event;
    logic [SW-1:0]    viol_event_src;
    viol_t            vstate;

    wprot_guard_decode #(.N_TGT(N_TGT), .AW(AW)) u_decode (
        .wr          (bus_wr),
        .addr        (bus_addr),
        .hit         (hit),
        .guarded_hit (guarded_hit),
        .prot_hit    (prot_hit)
    );

    wprot_guard_keyreg #(.DW(DW), .KW(KEY_W)) u_keyreg (
        .clk      (clk),
        .rst      (rst),
        .prot_hit (prot_hit),
        .key_in   (bus_wdata[KEY_LSB +: KEY_W]),
        .en_in    (bus_wdata[EN_BIT]),
        .prot_en  (prot_en),
        .key_bad  (key_bad),
        .rdata    (prot_rdata)
    );

    assign blocked        = guarded_hit && prot_en;
    assign reg_we         = blocked ? '0 : hit;
    assign viol_event     = blocked || key_bad;
    assign viol_event_src = SW'(bus_addr);

    wprot_guard_viol #(.SW(SW)) u_viol (
        .clk       (clk),
        .rst       (rst),
        .event_in  (viol_event),
        .event_src (viol_event_src),
        .clr       (stat_rd),
        .state     (vstate)
    );

    assign viol_flag = vstate.flag;
    assign viol_src  = vstate.src;

    always_comb begin
        stat_rdata                   = '0;
        stat_rdata[0]                = vstate.flag;
        stat_rdata[SRC_LSB +: SW]    = vstate.src;
    end

    assert_we_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_we));

    assert_guard_block_R6: assert property (@(posedge clk) disable iff (rst)
        (prot_en && guarded_hit) |-> (reg_we == '0));

    assert_cmd_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == tgt_offset(int'(TGT_CMD))) |-> reg_we[TGT_CMD]);

endmodule

// File: tb/tb_wprot_guard.sv
module tb_wprot_guard;
    import wprot_guard_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 22;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  we;
        logic        prot;
        logic        flag;
        logic [15:0] src;
    } vec_t;

    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b1, 1'b0, 8'h00, 32'h0,        8'h01, 1'b0, 1'b0, 16'h0000}, // R2 cmd
        '{1'b1, 1'b0, 8'h04, 32'h0,        8'h02, 1'b0, 1'b0, 16'h0000}, // R2 ien
        '{1'b1, 1'b0, 8'h08, 32'h0,        8'h04, 1'b0, 1'b0, 16'h0000}, // R2 idis
        '{1'b1, 1'b0, 8'h10, 32'h0,        8'h08, 1'b0, 1'b0, 16'h0000}, // R2 mode
        '{1'b1, 1'b0, 8'h14, 32'h0,        8'h10, 1'b0, 1'b0, 16'h0000}, // R2 frame
        '{1'b1, 1'b0, 8'h18, 32'h0,        8'h20, 1'b0, 1'b0, 16'h0000}, // R2 disp
        '{1'b1, 1'b0, 8'h1C, 32'h0,        8'h40, 1'b0, 1'b0, 16'h0000}, // R2 seg0
        '{1'b1, 1'b0, 8'h20, 32'h0,        8'h80, 1'b0, 1'b0, 16'h0000}, // R2 seg1
        '{1'b1, 1'b0, 8'h30, 32'h0,        8'h00, 1'b0, 1'b0, 16'h0000}, // R2 unmapped
        '{1'b1, 1'b0, 8'h40, 32'h4C434401, 8'h00, 1'b1, 1'b0, 16'h0000}, // R3 enable
        '{1'b1, 1'b0, 8'h10, 32'h0,        8'h00, 1'b1, 1'b1, 16'h0010}, // R6 mode blocked
        '{1'b1, 1'b0, 8'h00, 32'h0,        8'h01, 1'b1, 1'b1, 16'h0010}, // R7 cmd passes
        '{1'b1, 1'b0, 8'h20, 32'h0,        8'h00, 1'b1, 1'b1, 16'h0020}, // R6 overwrite
        '{1'b1, 1'b0, 8'h04, 32'h0,        8'h02, 1'b1, 1'b1, 16'h0020}, // R7 ien passes
        '{1'b0, 1'b1, 8'h00, 32'h0,        8'h00, 1'b1, 1'b0, 16'h0000}, // R9 clear
        '{1'b1, 1'b0, 8'h40, 32'h12345600, 8'h00, 1'b1, 1'b1, 16'h0040}, // R4 bad key on
        '{1'b1, 1'b1, 8'h18, 32'h0,        8'h00, 1'b1, 1'b1, 16'h0018}, // R9 read+viol
        '{1'b0, 1'b1, 8'h00, 32'h0,        8'h00, 1'b1, 1'b0, 16'h0000}, // R9 clear
        '{1'b1, 1'b0, 8'h40, 32'h4C434400, 8'h00, 1'b0, 1'b0, 16'h0000}, // R10 disable
        '{1'b1, 1'b0, 8'h14, 32'h0,        8'h10, 1'b0, 1'b0, 16'h0000}, // R2 frame again
        '{1'b1, 1'b0, 8'h40, 32'hFFFFFF01, 8'h00, 1'b0, 1'b1, 16'h0040}, // R4 bad key off
        '{1'b0, 1'b1, 8'h00, 32'h0,        8'h00, 1'b0, 1'b0, 16'h0000}  // R9 clear
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        stat_rd;
    logic [7:0]  reg_we;
    logic        prot_en;
    logic [31:0] prot_rdata;
    logic        viol_flag;
    logic [15:0] viol_src;
    logic [31:0] stat_rdata;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wprot_guard dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .stat_rd    (stat_rd),
        .reg_we     (reg_we),
        .prot_en    (prot_en),
        .prot_rdata (prot_rdata),
        .viol_flag  (viol_flag),
        .viol_src   (viol_src),
        .stat_rdata (stat_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic p, input logic f, input logic [15:0] s);
        check(req, {63'd0, prot_en}, {63'd0, p});
        check("R5", {32'd0, prot_rdata}, {32'd0, 31'd0, p});
        check(req, {63'd0, viol_flag}, {63'd0, f});
        check(req, {48'd0, viol_src}, {48'd0, s});
        check("R8", {32'd0, stat_rdata}, {32'd0, 8'h00, s, 7'd0, f});
    endtask

    task automatic idle();
        bus_wr    = 1'b0;
        bus_addr  = 8'h00;
        bus_wdata = 32'h0;
        stat_rd   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", {56'd0, reg_we}, 64'd0);
        check_state("R1", 1'b0, 1'b0, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bus_wr    = VEC[i].wr;
            stat_rd   = VEC[i].rd;
            bus_addr  = VEC[i].addr;
            bus_wdata = VEC[i].data;
            #1;
            check("R2/R6/R7 we", {56'd0, reg_we}, {56'd0, VEC[i].we});
            @(posedge clk);
            #1;
            check_state("R3/R4/R6/R9 state", VEC[i].prot, VEC[i].flag, VEC[i].src);
        end

        // R9: status read shows pre-clear value in the read cycle
        @(negedge clk);
        bus_wr = 1'b1; stat_rd = 1'b0; bus_addr = 8'h40; bus_wdata = 32'h4C434401;
        @(negedge clk);
        bus_addr = 8'h1C; bus_wdata = 32'h0;
        #1;
        check("R6 seg0 blocked", {56'd0, reg_we}, 64'd0);
        @(negedge clk);
        bus_wr = 1'b0; stat_rd = 1'b1;
        #1;
        check("R9 read value", {32'd0, stat_rdata}, {32'd0, 8'h00, 16'h001C, 7'd0, 1'b1});
        @(negedge clk);
        idle();
        #1;
        check_state("R9 after read", 1'b1, 1'b0, 16'h0000);

        // R4: key field with a one-bit error is rejected
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h4C434500;
        @(negedge clk);
        idle();
        #1;
        check_state("R4 near key", 1'b1, 1'b1, 16'h0040);

        // R7: interrupt-disable write still passes, no new violation
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        idle();
        bus_wr = 1'b1; bus_addr = 8'h08;
        #1;
        check("R7 idis we", {56'd0, reg_we}, 64'h04);
        @(negedge clk);
        idle();
        #1;
        check_state("R7 no viol", 1'b1, 1'b0, 16'h0000);

        // R1: reset mid-run clears protection and recorder
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h14;
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_state("R1 re-reset", 1'b0, 1'b0, 16'h0000);
        check("R1 we idle", {56'd0, reg_we}, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule